// File: doc/BRIEF.md
# Debug Scan Transaction Controller

This block is the transaction layer of a JTAG debug port and runs entirely in the test clock domain. The TAP state machine outside it supplies one-cycle strobes for the capture and update states of a data scan, plus two select lines that say whether the current scan targets the debug-port register group or the access-port register group. At the update strobe the block takes the shifted word, decodes a read/write flag, a 2-bit register address and 32 bits of write data, and starts the register access. Debug-port registers are served internally at once. Access-port accesses go to a back end as a request.

The outcome of an access is never returned in its own scan. It is loaded into the capture word at the capture strobe of the next debug scan. The acknowledge reads WAIT when the back end has not yet completed. It also reads WAIT when too few test clock cycles have passed since the last update, measured against a programmable floor. If overrun detection is enabled, any WAIT raises a sticky overrun flag. While that flag is set, access-port scans are answered at once with zero data and are never forwarded. Debug-port registers stay usable, so the debugger can read the flag and then clear it.

The request side carries no back-pressure: `req_valid` is a one-cycle pulse, and the back end must accept it in that cycle. The completion side is a one-cycle `rsp_valid` pulse with no ready signal. A completion that arrives while nothing is outstanding is ignored.

Top module: `dbg_scan_txn`

## Requirements
- R1: The update word is laid out as bit 0 = read flag (1 = read), bits [2:1] = register address, bits [34:3] = write data. The capture word is laid out as bits [2:0] = acknowledge, bits [34:3] = read data. An access started at the update strobe of one scan has its result loaded at the capture strobe of the next scan, and `cap_word` holds it from the clock edge of that capture.
- R2: Acknowledge 3'b010 means OK/FAULT and 3'b001 means WAIT. Capture gives WAIT with zero data if an access-port access is still outstanding. A completion that arrives in the same cycle as the capture still counts as outstanding. Otherwise capture gives 3'b010 together with the held result.
- R3: Control/status bits [15:8] hold a minimum turnaround. If capture falls fewer than that many cycles after the last update of any scan, the acknowledge is WAIT, even if the access has finished. Capture exactly that many cycles after the update is not delayed by this rule. Every cycle counts, whatever path the TAP takes.
- R4: A scan that received WAIT launches nothing at its update strobe. The outstanding access and its result are kept and delivered at a later capture.
- R5: When control/status bit 0 (overrun detect enable) is 1, every WAIT acknowledge sets the sticky overrun flag, bit 1. When bit 0 is 0, a WAIT leaves bit 1 unchanged.
- R6: While the sticky overrun flag is set, an access-port scan raises no request, and its result is OK/FAULT with zero data.
- R7: The control/status register is at debug-port address 2'b01. A read returns bit 0, bit 1, bit 2 and bits [15:8]; all other bits read as zero. A write loads bit 0 and bits [15:8]. Writing 1 to bit 1 or to bit 2 clears that bit.
- R8: A completion with `rsp_fault` high sets the sticky error bit, control/status bit 2. A faulted access or any write returns zero data.
- R9: After reset no access is outstanding, all control/status bits are zero, `cap_word` is zero and no request is raised. The turnaround count starts saturated, so the first capture returns 3'b010 with zero data.
- R10: An access-port launch drives `req_valid` high for exactly one cycle, after the update edge. In that cycle `req_rnw`, `req_addr` and `req_wdata` carry the fields of the update word.
- R11: Debug-port addresses other than 2'b01 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset |
| sel_dp | input | 1 | Current scan targets the debug-port registers |
| sel_ap | input | 1 | Current scan targets the access-port registers |
| upd_dr | input | 1 | One-cycle strobe for the update state of a data scan |
| cap_dr | input | 1 | One-cycle strobe for the capture state of a data scan |
| upd_word | input | 35 | Shifted word, valid at `upd_dr` |
| cap_word | output | 35 | Acknowledge and data to load into the scan register |
| req_valid | output | 1 | One-cycle access-port request pulse |
| req_rnw | output | 1 | Request is a read |
| req_addr | output | 2 | Request register address |
| req_wdata | output | 32 | Request write data |
| rsp_valid | input | 1 | One-cycle completion pulse from the back end |
| rsp_rdata | input | 32 | Completion read data |
| rsp_fault | input | 1 | Completion reports a fault |

## Verification
Back-end completion and the capture decision can land in the same clock cycle. The bench provokes this by sizing the idle gap after an access-port update to equal the back-end latency, so `rsp_valid` and the capture strobe meet at one edge. The expected outcome is WAIT at that capture and OK with the read data at the next one. A gap one cycle longer must give OK at once. The bench tests the turnaround floor in the same way, at one cycle below and exactly at the programmed count.

// File: rtl/dbg_txn_pkg.sv
package dbg_txn_pkg;
  localparam int ACK_W   = 3;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int SCAN_W  = ACK_W + DATA_W;

  localparam logic [ACK_W-1:0] ACK_OK   = 3'b010;
  localparam logic [ACK_W-1:0] ACK_WAIT = 3'b001;

  localparam logic [ADDR_W-1:0] CSR_ADDR = 2'b01;

  localparam int CSR_ODEN    = 0;
  localparam int CSR_ORUN    = 1;
  localparam int CSR_ERR     = 2;
  localparam int CSR_MIN_LSB = 8;

  typedef struct packed {
    logic [DATA_W-1:0] wdata;
    logic [ADDR_W-1:0] addr;
    logic              rnw;
  } upd_word_t;
endpackage

// File: rtl/dbg_turn_cnt.sv
module dbg_turn_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] SAT = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= SAT;
    end else if (restart) begin
      count <= W'(1);
    end else if (count != SAT) begin
      count <= count + W'(1);
    end
  end
endmodule

// File: rtl/dbg_ctrl_regs.sv
module dbg_ctrl_regs
  import dbg_txn_pkg::*;
#(
  parameter int TURN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_oden,
  input  logic              wr_clr_orun,
  input  logic              wr_clr_err,
  input  logic [TURN_W-1:0] wr_min,
  input  logic              set_orun,
  input  logic              set_err,
  output logic              oden,
  output logic              orun,
  output logic              err,
  output logic [TURN_W-1:0] min_turn,
  output logic [DATA_W-1:0] rd_value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oden     <= 1'b0;
      orun     <= 1'b0;
      err      <= 1'b0;
      min_turn <= '0;
    end else begin
      if (wr_en) begin
        oden     <= wr_oden;
        min_turn <= wr_min;
      end
      if (set_orun) begin
        orun <= 1'b1;
      end else if (wr_en && wr_clr_orun) begin
        orun <= 1'b0;
      end
      if (set_err) begin
        err <= 1'b1;
      end else if (wr_en && wr_clr_err) begin
        err <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_value = '0;
    rd_value[CSR_ODEN] = oden;
    rd_value[CSR_ORUN] = orun;
    rd_value[CSR_ERR]  = err;
    rd_value[CSR_MIN_LSB +: TURN_W] = min_turn;
  end
endmodule

// File: rtl/dbg_scan_txn.sv
module dbg_scan_txn
  import dbg_txn_pkg::*;
#(
  parameter int TURN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_dp,
  input  logic              sel_ap,
  input  logic              upd_dr,
  input  logic              cap_dr,
  input  logic [SCAN_W-1:0] upd_word,
  output logic [SCAN_W-1:0] cap_word,
  output logic              req_valid,
  output logic              req_rnw,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic              rsp_fault
);
  upd_word_t         uw;
  logic              scan_act, capture, update, launch;
  logic              early, give_wait;
  logic              busy, pend_rnw, last_wait;
  logic [DATA_W-1:0] result;
  logic [TURN_W-1:0] turn_cnt, min_turn;
  logic              oden, orun_sticky, err_sticky;
  logic [DATA_W-1:0] csr_rd;
  logic              csr_wr;

  assign uw        = upd_word_t'(upd_word);
  assign scan_act  = sel_dp | sel_ap;
  assign capture   = cap_dr & scan_act;
  assign update    = upd_dr & scan_act;
  assign launch    = update & ~last_wait;
  assign early     = turn_cnt < min_turn;
  assign give_wait = busy | early;
  assign csr_wr    = launch & sel_dp & ~uw.rnw & (uw.addr == CSR_ADDR);

  dbg_turn_cnt #(.W(TURN_W)) u_turn (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (update),
    .count   (turn_cnt)
  );

  dbg_ctrl_regs #(.TURN_W(TURN_W)) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (csr_wr),
    .wr_oden     (uw.wdata[CSR_ODEN]),
    .wr_clr_orun (uw.wdata[CSR_ORUN]),
    .wr_clr_err  (uw.wdata[CSR_ERR]),
    .wr_min      (uw.wdata[CSR_MIN_LSB +: TURN_W]),
    .set_orun    (capture & give_wait & oden),
    .set_err     (rsp_valid & busy & rsp_fault),
    .oden        (oden),
    .orun        (orun_sticky),
    .err         (err_sticky),
    .min_turn    (min_turn),
    .rd_value    (csr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pend_rnw  <= 1'b0;
      last_wait <= 1'b0;
      result    <= '0;
      cap_word  <= '0;
      req_valid <= 1'b0;
      req_rnw   <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      req_valid <= 1'b0;
      if (rsp_valid && busy) begin
        busy   <= 1'b0;
        result <= (pend_rnw && !rsp_fault) ? rsp_rdata : '0;
      end
      if (capture) begin
        last_wait <= give_wait;
        cap_word  <= give_wait ? {{DATA_W{1'b0}}, ACK_WAIT} : {result, ACK_OK};
      end
      if (launch) begin
        if (sel_ap && !orun_sticky) begin
          req_valid <= 1'b1;
          req_rnw   <= uw.rnw;
          req_addr  <= uw.addr;
          req_wdata <= uw.wdata;
          busy      <= 1'b1;
          pend_rnw  <= uw.rnw;
          result    <= '0;
        end else if (sel_ap) begin
          result <= '0;
        end else begin
          result <= (uw.rnw && uw.addr == CSR_ADDR) ? csr_rd : '0;
        end
      end
    end
  end
endmodule

// File: rtl/dbg_scan_txn_chk.sv
module dbg_scan_txn_chk
  import dbg_txn_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sel_ap,
  input logic             upd_dr,
  input logic             cap_dr,
  input logic             scan_act,
  input logic             req_valid,
  input logic [ACK_W-1:0] cap_ack,
  input logic             sticky,
  input logic             last_wait,
  input logic             early
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid); // R10

  AST_REQ_FROM_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(upd_dr && sel_ap)); // R1

  AST_NO_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !$past(sticky)); // R6

  AST_EARLY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_dr && scan_act && early) |=> (cap_ack == ACK_WAIT)); // R3

  AST_STICKY_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky) |-> ($past(cap_dr) && cap_ack == ACK_WAIT)); // R5

  AST_NO_LAUNCH_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_dr && sel_ap && last_wait) |=> !req_valid); // R4
endmodule

bind dbg_scan_txn dbg_scan_txn_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_ap    (sel_ap),
  .upd_dr    (upd_dr),
  .cap_dr    (cap_dr),
  .scan_act  (scan_act),
  .req_valid (req_valid),
  .cap_ack   (cap_word[2:0]),
  .sticky    (orun_sticky),
  .last_wait (last_wait),
  .early     (early)
);

// File: tb/test_dbg_scan_txn.sv
module test_dbg_scan_txn;
  localparam int CLK_PERIOD = 10;
  localparam int SHIFT_CYC  = 4;
  localparam logic [2:0] OK = 3'b010;
  localparam logic [2:0] WT = 3'b001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_dp = 1'b0, sel_ap = 1'b0, upd_dr = 1'b0, cap_dr = 1'b0;
  logic [34:0] upd_word = '0;
  logic [34:0] cap_word;
  logic        req_valid, req_rnw;
  logic [1:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0, rsp_fault = 1'b0;
  logic [31:0] rsp_rdata = '0;

  int checks = 0, failures = 0, req_cnt = 0, be_lat = 2;
  bit finished = 0;
  logic        cap_q;
  logic        last_rnw;
  logic [1:0]  last_addr;
  logic [31:0] last_wdata;

  typedef struct {
    logic [2:0]  ack;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_scan_txn i_dbg_scan_txn (
    .clk(clk), .rst_n(rst_n), .sel_dp(sel_dp), .sel_ap(sel_ap),
    .upd_dr(upd_dr), .cap_dr(cap_dr), .upd_word(upd_word), .cap_word(cap_word),
    .req_valid(req_valid), .req_rnw(req_rnw), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_fault(rsp_fault)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // back end: answers each request after be_lat cycles
  always begin
    @(negedge clk);
    if (req_valid) begin
      req_cnt++;
      last_rnw = req_rnw; last_addr = req_addr; last_wdata = req_wdata;
      repeat (be_lat) @(negedge clk);
      rsp_valid = 1'b1;
      rsp_rdata = 32'hC0DE_0000 | {30'd0, last_addr};
      rsp_fault = (last_addr == 2'd3);
      @(negedge clk);
      rsp_valid = 1'b0; rsp_fault = 1'b0; rsp_rdata = '0;
    end
  end

  // monitor: one expected item per capture
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cap_q <= 1'b0;
    else cap_q <= cap_dr & (sel_dp | sel_ap);

  always @(negedge clk) begin
    if (cap_q) begin
      if (exp_q.size() == 0) begin
        check(0, "scoreboard empty", 0, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cap_word == {e.data, e.ack}, e.tag, {29'd0, cap_word}, {29'd0, e.data, e.ack});
      end
    end
  end

  task automatic scan(input bit ap, input bit rnw, input logic [1:0] addr,
                      input logic [31:0] wd, input int idle,
                      input logic [2:0] eack, input logic [31:0] edata,
                      input string tag);
    exp_q.push_back('{eack, edata, tag});
    sel_ap = ap; sel_dp = !ap;
    cap_dr = 1'b1;
    @(negedge clk);
    cap_dr = 1'b0;
    repeat (SHIFT_CYC) @(negedge clk);
    upd_word = {wd, addr, rnw};
    upd_dr = 1'b1;
    @(negedge clk);
    upd_dr = 1'b0;
    repeat (idle) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cap_word == 0, "R9 reset cap_word", {29'd0, cap_word}, 0);
    check(req_valid == 0, "R9 reset no request", {63'd0, req_valid}, 0);

    scan(0, 0, 2'b01, 32'h0000_0001, 2,  OK, 32'h0, "R9 first capture OK zero");
    be_lat = 2;
    scan(1, 1, 2'b00, 32'h0,         10, OK, 32'h0, "R1 csr write result");
    be_lat = 20;
    scan(1, 1, 2'b00, 32'h0,         0,  OK, 32'hC0DE_0000, "R1 ap read data");
    scan(1, 1, 2'b01, 32'h0,         30, WT, 32'h0, "R2 outstanding gives WAIT");
    scan(1, 1, 2'b10, 32'h0,         5,  OK, 32'hC0DE_0000, "R4 retried result kept");
    scan(0, 1, 2'b01, 32'h0,         2,  OK, 32'h0, "R6 abandoned ap zero data");
    check(req_cnt == 2, "R6 no request while sticky", req_cnt, 2);
    scan(0, 0, 2'b01, 32'h0000_0A02, 0,  OK, 32'h3, "R5 sticky set by WAIT");
    scan(0, 1, 2'b01, 32'h0,         9,  WT, 32'h0, "R3 turnaround WAIT");
    scan(0, 1, 2'b01, 32'h0,         8,  OK, 32'h0, "R3 gap equal to min OK");
    scan(0, 1, 2'b00, 32'h0,         9,  WT, 32'h0, "R3 gap min-1 WAIT");
    be_lat = 2;
    scan(1, 0, 2'b11, 32'h1234_5678, 20, OK, 32'h0A00, "R7 csr fields, sticky cleared");
    check(req_cnt == 3, "R6 ap forwarded after clear", req_cnt, 3);
    check(last_rnw == 0 && last_addr == 2'd3, "R10 request fields",
          {61'd0, last_rnw, last_addr}, 64'd3);
    check(last_wdata == 32'h1234_5678, "R10 request wdata", last_wdata, 32'h1234_5678);
    scan(0, 1, 2'b01, 32'h0,         20, OK, 32'h0, "R8 faulted write zero data");
    scan(0, 0, 2'b01, 32'h0000_0004, 20, OK, 32'h0A04, "R8 sticky error set");
    be_lat = 3;
    scan(1, 1, 2'b01, 32'h0,         3,  OK, 32'h0, "R7 csr write result");
    scan(1, 1, 2'b10, 32'h0,         0,  WT, 32'h0, "R2 done same cycle as capture");
    scan(1, 1, 2'b10, 32'h0,         4,  OK, 32'hC0DE_0001, "R2 result after collision");
    scan(0, 1, 2'b01, 32'h0,         2,  OK, 32'hC0DE_0002, "R2 done one cycle early");
    scan(0, 0, 2'b10, 32'hFFFF_FFFF, 2,  OK, 32'h0, "R5 csr clean without enable");
    scan(0, 1, 2'b10, 32'h0,         2,  OK, 32'h0, "R11 write to other address");
    scan(0, 1, 2'b01, 32'h0,         2,  OK, 32'h0, "R11 other address reads zero");
    scan(0, 1, 2'b01, 32'h0,         2,  OK, 32'h0, "R11 csr unchanged");
    check(req_cnt == 5, "R1 total requests", req_cnt, 5);
    check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule